// File: doc/BRIEF.md
# Write Burst Cut-Point Decision

This block sits beside the target side of a bus bridge and decides, data phase by data phase, whether an incoming write burst may go on or must stop. Each cycle it sees the following inputs:

- the kind of write being accepted;
- the DWORD address inside the current 4 KB page;
- the cache line size register, in DWORDs;
- a line-cut enable bit taken from the chip control register;
- the number of free DWORD slots in the posted write buffer.

From these it drives three outputs: accept (take this DWORD), last (take it and disconnect), and hold (disconnect without taking data).

The decision is combinational on the live phase, so the target state machine can drive ready and stop in the same cycle. One register records that the burst has already been cut. Any further phase in that burst is then refused until the initiator drops its frame signal.

Top module: `wr_burst_cut`

## Requirements
- R1: Kind codes are 0 = delayed write, 1 = posted memory write, 2 = memory write and invalidate, and 3 = treated as delayed write. For kinds 0 and 3, every live phase before a cut gets accept and last, whatever the buffer space.
- R2: For a posted kind (1 or 2), a phase at the final DWORD of the 4 KB page (address all ones) gets last.
- R3: For kind 1 with line-cut enabled and a legal line size (1, 2, 4, 8 or 16), a phase at the final DWORD of a line (address modulo size equals size minus 1) gets last. With line-cut disabled, line ends do not cut.
- R4: For kind 2 with an illegal line size (anything other than 1, 2, 4, 8, 16, including 0), only the page end or a buffer condition cuts.
- R5: For kind 2 with line size 1, 2, 4 or 8, a line-end phase gets last exactly when free space is not more than the line size. That means the space left after this DWORD is smaller than one full line.
- R6: For kind 2 with line size 16, every 16-DWORD-aligned block end gets last, whatever the free space.
- R7: For a posted kind, free space of 1 gives accept with last. Free space of 0 gives hold with no accept.
- R8: After a phase that got last or hold, every later phase in the same burst gets hold and no accept. A cycle with frame low clears this.
- R9: With no live phase, all three outputs are low. After reset no cut is recorded.
- R10: accept and hold are never high together, and last is only high with accept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| frame_i | input | 1 | Initiator burst in progress |
| phase_i | input | 1 | Live data phase this cycle |
| kind_i | input | 2 | Write kind code |
| dw_addr_i | input | ADDR_W | DWORD address within 4 KB page |
| line_size_i | input | LS_W | Cache line size in DWORDs |
| line_cut_i | input | 1 | Line-cut enable for posted memory writes |
| fifo_free_i | input | FREE_W | Free DWORD slots in posted buffer (0..32) |
| accept_o | output | 1 | Take this DWORD |
| last_o | output | 1 | Take this DWORD and disconnect |
| hold_o | output | 1 | Disconnect without taking data |

## Verification
The only internal state is the cut-recorded flag. If that flag is wrong, it shows on the very next live phase of the same burst: a stuck-low flag lets accept through after a cut, and a stuck-high flag gives hold on a fresh burst's first phase. Errors in the boundary decode show on the same cycle as a missing or extra last at a line end, a page end or a low-space phase. The bench therefore steps bursts across every line size and space level, checking each phase at its own cycle.

// File: rtl/wr_burst_cut.sv
module wr_burst_cut #(
  parameter int ADDR_W   = 10,
  parameter int LS_W     = 8,
  parameter int FREE_W   = 6,
  parameter int MAX_LINE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_i,
  input  logic              phase_i,
  input  logic [1:0]        kind_i,
  input  logic [ADDR_W-1:0] dw_addr_i,
  input  logic [LS_W-1:0]   line_size_i,
  input  logic              line_cut_i,
  input  logic [FREE_W-1:0] fifo_free_i,
  output logic              accept_o,
  output logic              last_o,
  output logic              hold_o
);
  localparam logic [1:0] K_PMW = 2'd1;
  localparam logic [1:0] K_MWI = 2'd2;
  localparam logic [ADDR_W-1:0] PAGE_END = '1;

  logic done_q;

  wire posted    = (kind_i == K_PMW) || (kind_i == K_MWI);
  wire ls_legal  = ($countones(line_size_i) == 1) && (int'(line_size_i) <= MAX_LINE);
  wire full_line = int'(line_size_i) == MAX_LINE;
  wire [ADDR_W-1:0] ls_mask = ADDR_W'(line_size_i) - 1'b1;
  wire line_end  = ls_legal && ((dw_addr_i & ls_mask) == ls_mask);
  wire room_short = int'(fifo_free_i) <= int'(line_size_i);
  wire cut_line  = (kind_i == K_PMW) ? (line_cut_i && line_end)
                                     : (line_end && (full_line || room_short));
  wire cut_post  = (int'(fifo_free_i) == 1) || (dw_addr_i == PAGE_END) || cut_line;

  always_comb begin
    accept_o = 1'b0;
    last_o   = 1'b0;
    hold_o   = 1'b0;
    if (phase_i) begin
      if (done_q) hold_o = 1'b1;
      else if (!posted) begin
        accept_o = 1'b1;
        last_o   = 1'b1;
      end else if (fifo_free_i == '0) hold_o = 1'b1;
      else begin
        accept_o = 1'b1;
        last_o   = cut_post;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        done_q <= 1'b0;
    else if (!frame_i) done_q <= 1'b0;
    else if (phase_i && (last_o || hold_o)) done_q <= 1'b1;
  end

  a_r1_delayed_single: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_i && !done_q && !posted) |-> (accept_o && last_o));
  a_r2_page_end: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_i && posted && accept_o && dw_addr_i == PAGE_END) |-> last_o);
  a_r7_no_room: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_i && posted && fifo_free_i == '0) |-> (hold_o && !accept_o));
  a_r8_after_cut: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_i && phase_i && (last_o || hold_o)) |=> (!frame_i || !accept_o));
  a_r9_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !phase_i |-> !(accept_o || last_o || hold_o));
  a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(accept_o && hold_o) && (!last_o || accept_o));
endmodule

// File: tb/tb_wr_burst_cut.sv
module tb_wr_burst_cut;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame = 1'b0, phase = 1'b0, cut = 1'b0;
  logic [1:0] kind = 2'd0;
  logic [9:0] addr = '0;
  logic [7:0] ls = 8'd0;
  logic [5:0] free = 6'd0;
  logic acc, lst, hld;
  int total = 0, bad = 0;
  bit done_m = 1'b0;

  always #4 clk = ~clk;

  wr_burst_cut dut (.clk(clk), .rst_n(rst_n), .frame_i(frame), .phase_i(phase),
    .kind_i(kind), .dw_addr_i(addr), .line_size_i(ls), .line_cut_i(cut),
    .fifo_free_i(free), .accept_o(acc), .last_o(lst), .hold_o(hld));

  function automatic bit legal(input int s);
    return s == 1 || s == 2 || s == 4 || s == 8 || s == 16;
  endfunction

  function automatic logic [2:0] expect_out(input bit dn, input bit ph, input int k,
      input int a, input int s, input bit c, input int f);
    bit eol, l;
    if (!ph) return 3'b000;
    if (dn) return 3'b001;
    if (k == 0 || k == 3) return 3'b110;
    if (f == 0) return 3'b001;
    eol = legal(s) && ((a % s) == s - 1);
    l = (f == 1) || (a == 1023);
    if (k == 1) l = l || (c && eol);
    else l = l || (eol && (s == 16 || f <= s));
    return {1'b1, l, 1'b0};
  endfunction

  task automatic check(input string tag, input logic [2:0] got, input logic [2:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got acc/last/hold=%b expected %b", tag, got, exp);
    end
  endtask

  task automatic step(input string tag, input bit fr, input bit ph, input int k,
      input int a, input int s, input bit c, input int f);
    logic [2:0] e;
    @(negedge clk);
    frame = fr; phase = ph; kind = 2'(k); addr = 10'(a); ls = 8'(s);
    cut = c; free = 6'(f);
    #2;
    e = expect_out(done_m, ph, k, a, s, c, f);
    check(tag, {acc, lst, hld}, e);
    done_m = fr ? (done_m | (ph & (e[1] | e[0]))) : 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    bad++; total++;
    $display("FAIL watchdog: got running expected finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    #1; check("R9 reset", {acc, lst, hld}, 3'b000);
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    step("R9 idle", 0, 0, 1, 5, 4, 0, 20);
    step("R1 delayed", 1, 1, 0, 5, 4, 0, 0);
    step("R8 after delayed", 1, 1, 0, 6, 4, 0, 30);
    step("R8 clear", 0, 0, 0, 0, 4, 0, 30);
    step("R1 code3", 1, 1, 3, 9, 4, 0, 30);
    step("R8 clear", 0, 0, 0, 0, 4, 0, 30);
    step("R2 mid page", 1, 1, 1, 1022, 8, 0, 30);
    step("R2 page end", 1, 1, 1, 1023, 8, 0, 30);
    step("R8 hold", 1, 1, 1, 0, 8, 0, 30);
    step("R8 clear", 0, 0, 1, 0, 8, 0, 30);
    step("R3 line cut off", 1, 1, 1, 7, 8, 0, 30);
    step("R3 line cut on", 1, 1, 1, 15, 8, 1, 30);
    step("R8 clear", 0, 0, 1, 0, 8, 0, 30);
    step("R4 illegal size", 1, 1, 2, 11, 12, 0, 30);
    step("R4 size zero", 1, 1, 2, 15, 0, 0, 30);
    step("R5 room ok", 1, 1, 2, 7, 8, 0, 9);
    step("R5 room short", 1, 1, 2, 15, 8, 0, 8);
    step("R8 clear", 0, 0, 2, 0, 8, 0, 30);
    step("R5 size1", 1, 1, 2, 3, 1, 0, 2);
    step("R5 size1 short", 1, 1, 2, 4, 1, 0, 1);
    step("R8 clear", 0, 0, 2, 0, 8, 0, 30);
    step("R6 size16", 1, 1, 2, 31, 16, 0, 32);
    step("R8 clear", 0, 0, 2, 0, 8, 0, 30);
    step("R7 one slot", 1, 1, 1, 3, 8, 0, 1);
    step("R8 clear", 0, 0, 1, 0, 8, 0, 30);
    step("R7 no slot", 1, 1, 2, 3, 8, 0, 0);
    step("R10 hold kept", 1, 1, 2, 4, 8, 0, 30);
    step("R8 clear", 0, 0, 2, 0, 8, 0, 30);
    for (int i = 0; i < 4000; i++) begin
      int sizes[10] = '{0, 1, 2, 3, 4, 8, 12, 16, 32, 5};
      int s, a, f;
      bit fr;
      s = sizes[$urandom_range(0, 9)];
      a = ($urandom_range(0, 3) == 0) ? 1023 - $urandom_range(0, 20) : $urandom_range(0, 1023);
      f = $urandom_range(0, 32);
      fr = $urandom_range(0, 7) != 0;
      step("R10 random", fr, fr & ($urandom_range(0, 3) != 0), $urandom_range(0, 3),
           a, s, 1'($urandom_range(0, 1)), f);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule